// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block is the reservation unit of one processor in a shared-memory multiprocessor. A load-locked request records the word address it read from in a lock register and marks the reservation valid. It also returns the condition flags for the loaded word. The monitor then watches a shared stream of completed writes from every processor, its own included. Any write to the reserved word cancels the reservation.

A store-conditional request is compared against the reservation. If the reservation is intact and covers the same word, the monitor issues the memory write one cycle later and reports success. Otherwise it suppresses the write and reports failure in the overflow flag. Software then branches back on that flag and retries the sequence. Every store-conditional consumes the reservation, whether it succeeds or fails.

Flags are packed as a 4-bit vector: bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. All outputs are registered, so they show the result of a request one clock after the request is presented.

Top module: `llsc_monitor`

## Requirements
- R1: One cycle after a load-locked request (with no store-conditional in the same cycle), `flags_valid` is 1 and `flags_nzvc` holds N = bit 31 of the loaded word, Z = the word is zero, V = 0, and C = at least one of its four bytes is zero.
- R2: After a load-locked to address A, a store-conditional to any byte of the same word (bits 31:2 equal), with no intervening write to that word, succeeds. One cycle later `mem_wr_en` = 1, `mem_wr_addr` = the store address with bits 1:0 cleared, `mem_wr_data` = the store data, and `flags_nzvc` = 4'b0000.
- R3: A snooped write whose address matches the reserved word in bits 31:2, at any byte offset, cancels the reservation. A snooped write to a different word leaves it intact.
- R4: A failing store-conditional produces no memory write (`mem_wr_en` = 0 in the following cycle) and sets `flags_nzvc` = 4'b0010, i.e. only V is set.
- R5: Every store-conditional clears the reservation, so a second one without a new load-locked fails.
- R6: A new load-locked replaces any earlier reservation, and only the latest address is tracked.
- R7: A snooped write to the reserved word in the same cycle as a store-conditional makes that store fail. A snooped write to the load-locked word in the same cycle as the load-locked leaves no reservation.
- R8: A store-conditional to a word other than the reserved one fails.
- R9: When load-locked and store-conditional are requested in the same cycle, only the store-conditional is acted on. The load-locked neither sets a reservation nor produces flags.
- R10: After reset there is no reservation, and `mem_wr_en` and `flags_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_req | input | 1 | Load-locked request |
| ll_addr | input | 32 | Effective address of the load-locked |
| ll_rdata | input | 32 | Word read from memory by the load-locked |
| sc_req | input | 1 | Store-conditional request |
| sc_addr | input | 32 | Effective address of the store-conditional |
| sc_wdata | input | 32 | Data the store-conditional would write |
| snp_valid | input | 1 | A write by some processor completes this cycle |
| snp_addr | input | 32 | Address of the snooped write |
| mem_wr_en | output | 1 | Memory write strobe for a successful store-conditional |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data |
| flags_valid | output | 1 | `flags_nzvc` carries the result of a request |
| flags_nzvc | output | 4 | Condition flags {N,Z,V,C} |

## Verification
Two events in this block can land in the same clock: a snooped write, and a store-conditional or load-locked that touches the same word. The bench provokes both orders. It lines the snoop up exactly with the store-conditional, or with the load-locked that would set the reservation. It also offsets the snoop by a byte within the word, and places it on a neighbouring word. Each cycle the bench model decides success or failure from its own reservation bit. It compares the write strobe, write address, write data and flags with the registered outputs one edge later. A long random phase that draws all addresses from a small pool makes these collisions frequent.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  localparam nzvc_t NZVC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};
endpackage

// File: rtl/llsc_word_match.sv
// Word-granular address comparisons for the reservation and the store-conditional.
module llsc_word_match #(
  parameter int ADDR_W = 32,
  parameter int LSB    = 2
) (
  input  logic              resv_valid,
  input  logic [ADDR_W-1:0] resv_addr,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hits_resv,
  output logic              snp_hits_ll,
  output logic              sc_pass
);
  function automatic logic same_word(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return ((a ^ b) >> LSB) == '0;
  endfunction

  always_comb begin
    snp_hits_resv = snp_valid && resv_valid && same_word(snp_addr, resv_addr);
    snp_hits_ll   = snp_valid && same_word(snp_addr, ll_addr);
    sc_pass       = sc_req && resv_valid && same_word(sc_addr, resv_addr)
                    && !snp_hits_resv;
  end
endmodule

// File: rtl/llsc_resv_reg.sv
// Lock register plus its valid bit.
module llsc_resv_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  input  logic              take_killed,
  input  logic              drop,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  logic              valid_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    valid_d = valid;
    addr_d  = addr;
    addr_en = take;
    if (take) begin
      valid_d = !take_killed;
      addr_d  = take_addr;
    end else if (drop) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else begin
      valid <= valid_d;
      if (addr_en) addr <= addr_d;
    end
  end
endmodule

// File: rtl/llsc_flag_gen.sv
// Condition flags for load-locked and store-conditional results.
module llsc_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic              is_sc,
  input  logic              sc_pass,
  input  logic [DATA_W-1:0] ld_word,
  output llsc_pkg::nzvc_t   flags
);
  localparam int NBYTES = DATA_W / 8;

  logic [NBYTES-1:0] byte_zero;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign byte_zero[g] = ld_word[g*8 +: 8] == 8'h00;
  end

  always_comb begin
    flags = llsc_pkg::NZVC_CLEAR;
    if (is_sc) begin
      flags.v = !sc_pass;
    end else begin
      flags.n = ld_word[DATA_W-1];
      flags.z = ld_word == '0;
      flags.c = |byte_zero;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic [DATA_W-1:0] ll_rdata,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [DATA_W-1:0] sc_wdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              flags_valid,
  output logic [3:0]        flags_nzvc
);
  localparam int LSB = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LSB) - 1);

  logic              resv_valid;
  logic [ADDR_W-1:0] resv_addr;
  logic              snp_hits_resv, snp_hits_ll, sc_pass;
  logic              ll_take;
  llsc_pkg::nzvc_t   flags_d;

  logic              wr_en_d, fv_d, flags_en, wr_en_cap;
  logic [ADDR_W-1:0] wr_addr_d;

  assign ll_take = ll_req && !sc_req;

  llsc_word_match #(.ADDR_W(ADDR_W), .LSB(LSB)) u_match (
    .resv_valid   (resv_valid),
    .resv_addr    (resv_addr),
    .sc_req       (sc_req),
    .sc_addr      (sc_addr),
    .ll_addr      (ll_addr),
    .snp_valid    (snp_valid),
    .snp_addr     (snp_addr),
    .snp_hits_resv(snp_hits_resv),
    .snp_hits_ll  (snp_hits_ll),
    .sc_pass      (sc_pass)
  );

  llsc_resv_reg #(.ADDR_W(ADDR_W)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (ll_take),
    .take_addr  (ll_addr),
    .take_killed(snp_hits_ll),
    .drop       (sc_req || snp_hits_resv),
    .valid      (resv_valid),
    .addr       (resv_addr)
  );

  llsc_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .is_sc  (sc_req),
    .sc_pass(sc_pass),
    .ld_word(ll_rdata),
    .flags  (flags_d)
  );

  always_comb begin
    wr_en_d   = sc_pass;
    wr_en_cap = sc_req;
    wr_addr_d = sc_addr & ~LOW_MASK;
    fv_d      = sc_req || ll_take;
    flags_en  = fv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      flags_valid <= 1'b0;
      flags_nzvc  <= '0;
    end else begin
      mem_wr_en   <= wr_en_d;
      flags_valid <= fv_d;
      if (wr_en_cap) begin
        mem_wr_addr <= wr_addr_d;
        mem_wr_data <= sc_wdata;
      end
      if (flags_en) flags_nzvc <= flags_d;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ll_req,
  input logic              sc_req,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              resv_valid,
  input logic [ADDR_W-1:0] resv_addr,
  input logic              mem_wr_en,
  input logic              flags_valid,
  input logic [3:0]        flags_nzvc
);
  // R4 / R2: a write strobe always comes with valid, all-clear flags
  a_r2_write_clean_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (flags_valid && flags_nzvc == 4'b0000));

  // R10: no write is issued without a reservation held the cycle before
  a_r10_no_resv_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !resv_valid) |=> !mem_wr_en);

  // R5: reservation gone after any store-conditional
  a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !resv_valid);

  // R3: snooped write to the reserved word cancels it
  a_r3_snoop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && resv_valid && !ll_req && !sc_req &&
     (snp_addr[ADDR_W-1:2] == resv_addr[ADDR_W-1:2])) |=> !resv_valid);

  // R9: a combined request produces a store-conditional result only
  a_r9_sc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_req && sc_req && !resv_valid) |=> (flags_nzvc == 4'b0010 && !resv_valid));

  // R1: load-locked flags never carry V
  a_r1_ll_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_req && !sc_req) |=> (flags_valid && !flags_nzvc[1]));
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ll_req     (ll_req),
  .sc_req     (sc_req),
  .snp_valid  (snp_valid),
  .snp_addr   (snp_addr),
  .resv_valid (resv_valid),
  .resv_addr  (resv_addr),
  .mem_wr_en  (mem_wr_en),
  .flags_valid(flags_valid),
  .flags_nzvc (flags_nzvc)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ll_req, sc_req, snp_valid;
  logic [31:0] ll_addr, ll_rdata, sc_addr, sc_wdata, snp_addr;
  logic        mem_wr_en, flags_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  flags_nzvc;

  int vectors = 0;
  int misses  = 0;

  // bench reference state
  bit          m_rv;
  logic [31:0] m_ra;
  logic        e_en, e_fv;
  logic [31:0] e_addr, e_data;
  logic [3:0]  e_flags;

  always #2.5 clk = ~clk;

  llsc_monitor i_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .ll_req(ll_req), .ll_addr(ll_addr), .ll_rdata(ll_rdata),
    .sc_req(sc_req), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .flags_valid(flags_valid), .flags_nzvc(flags_nzvc)
  );

  function automatic bit wsame(logic [31:0] a, logic [31:0] b);
    return a[31:2] == b[31:2];
  endfunction

  function automatic logic [3:0] ld_flags(logic [31:0] d);
    bit c = 0;
    for (int i = 0; i < 4; i++) if (d[i*8 +: 8] == 8'h00) c = 1;
    return {d[31], d == 32'h0, 1'b0, c};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive inputs, advance model, compare registered outputs
  task automatic step(string req, bit ll, logic [31:0] la, logic [31:0] ld,
                      bit sc, logic [31:0] sa, logic [31:0] sd,
                      bit sn, logic [31:0] na);
    bit pass;
    ll_req = ll; ll_addr = la; ll_rdata = ld;
    sc_req = sc; sc_addr = sa; sc_wdata = sd;
    snp_valid = sn; snp_addr = na;
    if (sc) begin
      pass    = m_rv && wsame(sa, m_ra) && !(sn && wsame(na, m_ra));
      e_en    = pass;
      e_fv    = 1;
      e_flags = pass ? 4'b0000 : 4'b0010;
      e_addr  = {sa[31:2], 2'b00};
      e_data  = sd;
      m_rv    = 0;
    end else if (ll) begin
      e_en    = 0;
      e_fv    = 1;
      e_flags = ld_flags(ld);
      m_rv    = !(sn && wsame(na, la));
      m_ra    = la;
    end else begin
      e_en = 0;
      e_fv = 0;
      if (sn && m_rv && wsame(na, m_ra)) m_rv = 0;
    end
    @(posedge clk);
    #1;
    chk({req, " wr_en"}, 32'(mem_wr_en), 32'(e_en));
    chk({req, " flags_valid"}, 32'(flags_valid), 32'(e_fv));
    if (e_en) begin
      chk({req, " wr_addr"}, mem_wr_addr, e_addr);
      chk({req, " wr_data"}, mem_wr_data, e_data);
    end
    if (e_fv) chk({req, " flags"}, 32'(flags_nzvc), 32'(e_flags));
    @(negedge clk);
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    ll_req = 0; sc_req = 0; snp_valid = 0;
    ll_addr = 0; ll_rdata = 0; sc_addr = 0; sc_wdata = 0; snp_addr = 0;
    m_rv = 0; m_ra = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset wr_en", 32'(mem_wr_en), 0);
    chk("R10 reset flags_valid", 32'(flags_valid), 0);
    rst_n = 1;
    @(negedge clk);
    step("R10 sc after reset", 0, 0, 0, 1, 32'h100, 32'h11, 0, 0);

    // R1: load-locked flag patterns
    step("R1 negative",  1, 32'h200, 32'h8123_4567, 0, 0, 0, 0, 0);
    step("R1 zero",      1, 32'h200, 32'h0000_0000, 0, 0, 0, 0, 0);
    step("R1 byte zero", 1, 32'h200, 32'h1200_3456, 0, 0, 0, 0, 0);
    step("R1 plain",     1, 32'h200, 32'h0101_0101, 0, 0, 0, 0, 0);

    // R2: success at another byte of the same word
    step("R2 ll",  1, 32'h300, 32'h5, 0, 0, 0, 0, 0);
    idle("R2 gap");
    step("R2 sc",  0, 0, 0, 1, 32'h303, 32'hCAFE_F00D, 0, 0);
    // R5: second store-conditional fails
    step("R5 sc again", 0, 0, 0, 1, 32'h300, 32'h1, 0, 0);

    // R3: foreign word keeps, same word (byte offset) cancels
    step("R3 ll",  1, 32'h400, 32'h5, 0, 0, 0, 0, 0);
    step("R3 other word", 0, 0, 0, 0, 0, 0, 1, 32'h404);
    step("R3 sc keep", 0, 0, 0, 1, 32'h400, 32'h22, 0, 0);
    step("R3 ll2", 1, 32'h400, 32'h5, 0, 0, 0, 0, 0);
    step("R3 snoop hit", 0, 0, 0, 0, 0, 0, 1, 32'h402);
    step("R4 sc fail", 0, 0, 0, 1, 32'h400, 32'h33, 0, 0);

    // R6: replacement
    step("R6 ll a", 1, 32'h500, 32'h5, 0, 0, 0, 0, 0);
    step("R6 ll b", 1, 32'h600, 32'h5, 0, 0, 0, 0, 0);
    step("R8 sc old", 0, 0, 0, 1, 32'h500, 32'h44, 0, 0);
    step("R6 ll c", 1, 32'h600, 32'h5, 0, 0, 0, 0, 0);
    step("R6 sc new", 0, 0, 0, 1, 32'h600, 32'h55, 0, 0);

    // R7: same-cycle snoops
    step("R7 ll", 1, 32'h700, 32'h5, 0, 0, 0, 0, 0);
    step("R7 sc+snoop", 0, 0, 0, 1, 32'h700, 32'h66, 1, 32'h701);
    step("R7 ll+snoop", 1, 32'h700, 32'h5, 0, 0, 0, 1, 32'h700);
    step("R7 sc after", 0, 0, 0, 1, 32'h700, 32'h77, 0, 0);
    step("R7 ll+far snoop", 1, 32'h700, 32'h5, 0, 0, 0, 1, 32'h800);
    step("R7 sc ok", 0, 0, 0, 1, 32'h700, 32'h88, 0, 0);

    // R8: mismatched word
    step("R8 ll", 1, 32'h900, 32'h5, 0, 0, 0, 0, 0);
    step("R8 sc wrong", 0, 0, 0, 1, 32'h904, 32'h99, 0, 0);

    // R9: combined request
    step("R9 ll", 1, 32'hA00, 32'h5, 0, 0, 0, 0, 0);
    step("R9 both", 1, 32'hB00, 32'h0, 1, 32'hA00, 32'hAA, 0, 0);
    step("R9 sc at ll addr", 0, 0, 0, 1, 32'hB00, 32'hBB, 0, 0);

    // random mix over a small address pool
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] la, sa, na;
      la = {26'h0, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom)};
      sa = {26'h0, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom)};
      na = {26'h0, 2'($urandom_range(0, 3)), 2'b00, 2'($urandom)};
      step("R2 R3 R7 random", ($urandom % 3) == 0, la, $urandom,
           ($urandom % 3) == 0, sa, $urandom, ($urandom % 4) == 0, na);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule